// File: doc/BRIEF.md
# Banked RAM Card Switch Controller

This block controls a 128 KB expansion memory card that shows one 16 KB slice of its RAM at a time in the top CPU window (D000–FFFF). The card holds eight such 16 KB blocks. Sixteen card-local soft switches, selected by a 4-bit index, set four pieces of state:

- where reads in the window come from (card RAM or system ROM);
- a small write counter that must reach its open value before RAM writes pass;
- which of two 4 KB banks appears at D000–DFFF;
- which 16 KB block is active.

Each CPU access in the window becomes a registered RAM-read, ROM-read or RAM-write strobe, together with a 17-bit RAM address. The address is the block number followed by a 14-bit offset. Inside a block the offset runs in this order: first 4 KB bank, second 4 KB bank, then the shared 8 KB.

A single-cycle `sw_sel` strobe marks a switch access. It stands for a read or a write to the switch address alike, since both directions have the same effect. The new state applies from the next clock edge. Any CPU access sampled on that same edge is still mapped with the state from before the switch.

Top module: `lcsw_card`

## Requirements
- R1: After synchronous reset the state is: reads from ROM, write counter at its open value 2, alternate-bank flag set, block 0 active. So a read at D000 gives `rom_rd` with address 0, and a write passes at once.
- R2: Control switches with index bits [1:0] = 00 select RAM as the read source. Index bits [1:0] = 10 select ROM. Both force the write counter to 0, which blocks writes.
- R3: Index bits [1:0] = 01 select ROM and [1:0] = 11 select RAM. Both advance the 2-bit write counter by one, holding it at 2. RAM writes pass only while the counter is 2, so two odd-switch accesses in a row are needed after a blocking switch.
- R4: Control switches (index bit 2 = 0) load the alternate-bank flag from index bit 3. Indices 0–3 clear it and indices 8–11 set it.
- R5: Switches with index bit 2 = 1 load the block number {idx[3], idx[1:0]}: indices 4–7 select blocks 0–3 and indices 12–15 select blocks 4–7. They leave the read source, the write counter and the alternate-bank flag unchanged.
- R6: For D000–DFFF the offset is addr[11:0] when the alternate flag is set, and 0x1000 + addr[11:0] when it is clear. For E000–FFFF the offset is 0x2000 + addr[12:0]. `ram_addr` = {block, offset}.
- R7: A valid read in the window raises `ram_rd` if the source is RAM and `rom_rd` if it is ROM. A valid write raises `ram_wr` only when the counter is 2. An invalid access or an address below D000 gives no strobe and `ram_addr` = 0. A valid window access with no strobe still reports its mapped address.
- R8: Outputs are registered: they reflect the access one cycle later. A switch and a CPU access on the same edge map the access with the state from before the switch.
- R9: While `sw_sel` is low, `sw_idx` has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_sel | input | 1 | Single-cycle strobe: a switch address was accessed |
| sw_idx | input | 4 | Index of the accessed switch |
| cpu_valid | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| ram_rd | output | 1 | Registered RAM read strobe |
| rom_rd | output | 1 | Registered ROM read strobe |
| ram_wr | output | 1 | Registered RAM write strobe |
| ram_addr | output | 17 | Registered card RAM address |

## Verification
A switch access and a CPU window access can fall in the same cycle. The vector table drives both together many times: a source flip with a read, a block change with a read, a counter step with a write, and a bank change with a D-range read. Each outcome is judged against the strobe and address that the state from before the switch gives. The next vector, with the same CPU access and no switch, then shows the new state.

// File: rtl/lcsw_pkg.sv
package lcsw_pkg;
  localparam int LC_BLOCKS = 8;
  localparam int BLK_W     = $clog2(LC_BLOCKS);
  localparam int OFF_W     = 14;
  localparam int RAM_AW    = BLK_W + OFF_W;
  localparam int CPU_AW    = 16;
  localparam int SW_W      = 4;
  localparam int WCNT_W    = 2;
  localparam logic [WCNT_W-1:0] WCNT_ON  = 2'd2;
  localparam logic [WCNT_W-1:0] WCNT_OFF = 2'd0;

  typedef struct packed {
    logic             is_blk;
    logic [BLK_W-1:0] blk;
    logic             alt;
    logic             rd_ram;
    logic             wadv;
  } lcsw_cmd_t;
endpackage

// File: rtl/lcsw_decode.sv
module lcsw_decode
  import lcsw_pkg::*;
(
  input  logic [SW_W-1:0] idx,
  output lcsw_cmd_t       cmd
);
  always_comb begin
    cmd.is_blk = idx[2];
    cmd.blk    = {idx[3], idx[1:0]};
    cmd.alt    = idx[3];
    cmd.rd_ram = (idx[1] == idx[0]);
    cmd.wadv   = idx[0];
  end
endmodule

// File: rtl/lcsw_state.sv
module lcsw_state
  import lcsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_sel,
  input  lcsw_cmd_t         cmd,
  output logic              rd_ram,
  output logic [WCNT_W-1:0] wcnt,
  output logic              alt,
  output logic [BLK_W-1:0]  blk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ram <= 1'b0;
      wcnt   <= WCNT_ON;
      alt    <= 1'b1;
      blk    <= '0;
    end else if (sw_sel) begin
      if (cmd.is_blk) begin
        blk <= cmd.blk;
      end else begin
        rd_ram <= cmd.rd_ram;
        alt    <= cmd.alt;
        if (!cmd.wadv)
          wcnt <= WCNT_OFF;
        else if (wcnt != WCNT_ON)
          wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcsw_map.sv
module lcsw_map
  import lcsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              rd_ram,
  input  logic [WCNT_W-1:0] wcnt,
  input  logic              alt,
  input  logic [BLK_W-1:0]  blk,
  output logic              ram_rd,
  output logic              rom_rd,
  output logic              ram_wr,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [3:0]       page;
  logic             in_win;
  logic             hit;
  logic [OFF_W-1:0] off;

  always_comb begin
    page   = cpu_addr[CPU_AW-1 -: 4];
    in_win = (page >= 4'hD);
    hit    = cpu_valid && in_win;
    if (page == 4'hD)
      off = alt ? {2'b00, cpu_addr[11:0]} : {2'b01, cpu_addr[11:0]};
    else
      off = {1'b1, cpu_addr[12:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_rd   <= 1'b0;
      rom_rd   <= 1'b0;
      ram_wr   <= 1'b0;
      ram_addr <= '0;
    end else begin
      ram_rd   <= hit && !cpu_we && rd_ram;
      rom_rd   <= hit && !cpu_we && !rd_ram;
      ram_wr   <= hit && cpu_we && (wcnt == WCNT_ON);
      ram_addr <= hit ? {blk, off} : '0;
    end
  end
endmodule

// File: rtl/lcsw_card.sv
module lcsw_card
  import lcsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_sel,
  input  logic [SW_W-1:0]   sw_idx,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              ram_rd,
  output logic              rom_rd,
  output logic              ram_wr,
  output logic [RAM_AW-1:0] ram_addr
);
  lcsw_cmd_t         cmd;
  logic              st_rd_ram;
  logic [WCNT_W-1:0] st_wcnt;
  logic              st_alt;
  logic [BLK_W-1:0]  st_blk;

  lcsw_decode u_dec (
    .idx (sw_idx),
    .cmd (cmd)
  );

  lcsw_state u_st (
    .clk    (clk),
    .rst    (rst),
    .sw_sel (sw_sel),
    .cmd    (cmd),
    .rd_ram (st_rd_ram),
    .wcnt   (st_wcnt),
    .alt    (st_alt),
    .blk    (st_blk)
  );

  lcsw_map u_map (
    .clk       (clk),
    .rst       (rst),
    .cpu_valid (cpu_valid),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .rd_ram    (st_rd_ram),
    .wcnt      (st_wcnt),
    .alt       (st_alt),
    .blk       (st_blk),
    .ram_rd    (ram_rd),
    .rom_rd    (rom_rd),
    .ram_wr    (ram_wr),
    .ram_addr  (ram_addr)
  );
endmodule

// File: rtl/lcsw_card_chk.sv
module lcsw_card_chk
  import lcsw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sw_sel,
  input logic [SW_W-1:0]   sw_idx,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic [3:0]        cpu_page,
  input logic              ram_rd,
  input logic              rom_rd,
  input logic              ram_wr,
  input logic              st_rd_ram,
  input logic [WCNT_W-1:0] st_wcnt,
  input logic              st_alt,
  input logic [BLK_W-1:0]  st_blk
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!st_rd_ram && st_wcnt == WCNT_ON && st_alt && st_blk == '0));

  p_clear_count_r2: assert property (@(posedge clk) disable iff (rst)
    (sw_sel && !sw_idx[2] && !sw_idx[0]) |=> (st_wcnt == WCNT_OFF));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    st_wcnt <= WCNT_ON);

  p_alt_load_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_sel && !sw_idx[2]) |=> (st_alt == $past(sw_idx[3])));

  p_block_load_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_sel && sw_idx[2]) |=> (st_blk == {$past(sw_idx[3]), $past(sw_idx[1:0])}
      && $stable(st_rd_ram) && $stable(st_wcnt) && $stable(st_alt)));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_rd, rom_rd, ram_wr}));

  p_write_gate_r7: assert property (@(posedge clk) disable iff (rst)
    ram_wr |-> ($past(st_wcnt) == WCNT_ON && $past(cpu_we) && $past(cpu_valid)));

  p_window_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_rd || rom_rd || ram_wr) |-> ($past(cpu_valid) && $past(cpu_page) >= 4'hD));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sw_sel |=> ($stable(st_rd_ram) && $stable(st_wcnt) && $stable(st_alt) && $stable(st_blk)));
endmodule

bind lcsw_card lcsw_card_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_sel    (sw_sel),
  .sw_idx    (sw_idx),
  .cpu_valid (cpu_valid),
  .cpu_we    (cpu_we),
  .cpu_page  (cpu_addr[15:12]),
  .ram_rd    (ram_rd),
  .rom_rd    (rom_rd),
  .ram_wr    (ram_wr),
  .st_rd_ram (st_rd_ram),
  .st_wcnt   (st_wcnt),
  .st_alt    (st_alt),
  .st_blk    (st_blk)
);

// File: tb/tb_lcsw_card.sv
module tb_lcsw_card;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_sel = 1'b0;
  logic [3:0]  sw_idx = 4'h0;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        ram_rd, rom_rd, ram_wr;
  logic [16:0] ram_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcsw_card dut (
    .clk(clk), .rst(rst), .sw_sel(sw_sel), .sw_idx(sw_idx),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .ram_rd(ram_rd), .rom_rd(rom_rd), .ram_wr(ram_wr), .ram_addr(ram_addr)
  );

  typedef struct packed {
    logic        sel;
    logic [3:0]  idx;
    logic        v;
    logic        we;
    logic [15:0] a;
    logic        erd;
    logic        erom;
    logic        ewr;
    logic [16:0] ea;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'hD123, 1'b0, 1'b1, 1'b0, 17'h00123},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hE456, 1'b0, 1'b0, 1'b1, 17'h02456},
    '{1'b1, 4'h0, 1'b1, 1'b0, 16'hD010, 1'b0, 1'b1, 1'b0, 17'h00010},
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'hD010, 1'b1, 1'b0, 1'b0, 17'h01010},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hD010, 1'b0, 1'b0, 1'b0, 17'h01010},
    '{1'b1, 4'h1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b1, 4'h1, 1'b1, 1'b1, 16'hF000, 1'b0, 1'b0, 1'b0, 17'h03000},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hF000, 1'b0, 1'b0, 1'b1, 17'h03000},
    '{1'b1, 4'h5, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0, 17'h03FFF},
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0, 17'h07FFF},
    '{1'b1, 4'hB, 1'b1, 1'b0, 16'hD800, 1'b0, 1'b1, 1'b0, 17'h05800},
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'hD800, 1'b1, 1'b0, 1'b0, 17'h04800},
    '{1'b1, 4'hF, 1'b1, 1'b1, 16'hDFFF, 1'b0, 1'b0, 1'b1, 17'h04FFF},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hE000, 1'b0, 1'b0, 1'b1, 17'h1E000},
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'hCFFF, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b1, 4'hA, 1'b1, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hE000, 1'b0, 1'b0, 1'b0, 17'h1E000},
    '{1'b1, 4'h9, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b1, 4'h2, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b1, 4'h3, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hE000, 1'b0, 1'b0, 1'b0, 17'h1E000},
    '{1'b1, 4'hC, 1'b1, 1'b0, 16'hD000, 1'b1, 1'b0, 1'b0, 17'h1D000},
    '{1'b0, 4'h0, 1'b1, 1'b0, 16'hD000, 1'b1, 1'b0, 1'b0, 17'h11000},
    '{1'b0, 4'h0, 1'b0, 1'b0, 16'hD000, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b1, 4'h3, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 17'h00000},
    '{1'b0, 4'h0, 1'b1, 1'b1, 16'hD000, 1'b0, 1'b0, 1'b1, 17'h11000}
  };

  task automatic step(input logic sel, input logic [3:0] idx, input logic v,
                      input logic we, input logic [15:0] a);
    @(negedge clk);
    sw_sel = sel; sw_idx = idx; cpu_valid = v; cpu_we = we; cpu_addr = a;
    @(posedge clk);
    #1;
    sw_sel = 1'b0; cpu_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic erd, input logic erom,
                            input logic ewr, input logic [16:0] ea);
    checks++;
    if ({ram_rd, rom_rd, ram_wr, ram_addr} !== {erd, erom, ewr, ea}) begin
      errors++;
      $display("FAIL %s: got rd=%b rom=%b wr=%b addr=%h, expected rd=%b rom=%b wr=%b addr=%h",
               tag, ram_rd, rom_rd, ram_wr, ram_addr, erd, erom, ewr, ea);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    expect_out("R1 reset outputs", 1'b0, 1'b0, 1'b0, 17'h0);

    // Table walk: covers R2..R9 including switch and access on the same edge (R8)
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].sel, VECS[i].idx, VECS[i].v, VECS[i].we, VECS[i].a);
      expect_out($sformatf("R6 R7 R8 vector %0d", i),
                 VECS[i].erd, VECS[i].erom, VECS[i].ewr, VECS[i].ea);
    end

    // R1: reset mid-run restores ROM read, open writes, alt set, block 0
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    step(1'b0, 4'h0, 1'b1, 1'b0, 16'hD456);
    expect_out("R1 read after reset", 1'b0, 1'b1, 1'b0, 17'h00456);
    step(1'b0, 4'h0, 1'b1, 1'b1, 16'hFABC);
    expect_out("R1 write after reset", 1'b0, 1'b0, 1'b1, 17'h03ABC);

    // R3: one odd access after a blocking one is not enough
    step(1'b1, 4'h8, 1'b0, 1'b0, 16'h0);
    step(1'b1, 4'h9, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h0, 1'b1, 1'b1, 16'hE001);
    expect_out("R3 single odd access", 1'b0, 1'b0, 1'b0, 17'h02001);

    // R5: a block switch between odd accesses keeps the count
    step(1'b1, 4'h6, 1'b0, 1'b0, 16'h0);
    step(1'b1, 4'hB, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h0, 1'b1, 1'b1, 16'hE001);
    expect_out("R5 block switch keeps count", 1'b0, 1'b0, 1'b1, 17'h0A001);

    // R3: saturation, many odd accesses then a single blocking one
    for (int k = 0; k < 5; k++) step(1'b1, 4'h3, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h0, 1'b1, 1'b1, 16'hD002);
    expect_out("R3 saturated write", 1'b0, 1'b0, 1'b1, 17'h09002);
    step(1'b1, 4'h2, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h0, 1'b1, 1'b1, 16'hD002);
    expect_out("R2 blocking after saturation", 1'b0, 1'b0, 1'b0, 17'h09002);

    // R4: bank flag from index bit 3, seen on D-range offset
    step(1'b1, 4'h8, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h0, 1'b1, 1'b0, 16'hD002);
    expect_out("R4 alt set bank", 1'b1, 1'b0, 1'b0, 17'h08002);

    // R9: sw_idx toggling with sw_sel low changes nothing
    step(1'b0, 4'h7, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h2, 1'b0, 1'b0, 16'h0);
    step(1'b0, 4'h0, 1'b1, 1'b0, 16'hD002);
    expect_out("R9 idle index ignored", 1'b1, 1'b0, 1'b0, 17'h08002);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule